// File: doc/BRIEF.md
# Register-Aliased Vector Issue Sequencer

This block takes one register-to-register instruction in scalar form (an operation plus destination and two source register numbers) and turns it into a run of element operations on a single 32-entry register file. There is no separate vector storage. Each register number has its own length entry in a small table. An operand named by register `r` with length `N` covers registers `r` up to `r+N-1`, so a vector is just a group of neighbouring scalar registers. One element is processed per clock by an internal ALU that does add, subtract, multiply, exclusive-or and unsigned divide.

The mix of operand lengths selects the form, and the opcode plays no part in it. If all lengths match, the form is element by element. A source of length 1 is reused for every element. A destination of length 1 with a longer source folds the elements into one register, one element per cycle. `busy` is high while elements are being issued, and `done` pulses once at the end. Instructions that cannot be run pulse `illegal` and write nothing. A preload port and a combinational read port give the host direct access to the register file.

Top module: `vreg_seq`

## Requirements
- R1: After reset every length entry is 1, every register reads 0, and `busy`, `done` and `illegal` are low. With all lengths at 1, an instruction acts as one scalar operation and writes only the destination.
- R2: A preload write (`pre_we`) stores `pre_data` into register `pre_addr` when `busy` is low and is ignored while `busy` is high. `rd_data` always shows register `rd_addr`.
- R3: A length write (`len_we`) sets the entry for `len_idx` to `len_val` when `busy` is low and is ignored while `busy` is high. Setting a length back to 1 restores scalar behaviour, and values already in the register file stay visible.
- R4: In the non-folding form, the element count n equals the destination length. Element i writes `rd+i` from source elements `rs1+i` and `rs2+i`. `busy` stays high for exactly n cycles after the accepting edge, and `done` is high for one cycle right after them.
- R5: A source of length 1 supplies the same register for every element, whatever the length of the other operands.
- R6: When the destination length is 1 and a source is longer than 1, the instruction folds. Element values e_i = src1_i op src2_i are formed for i below n = max(source lengths). The accumulator starts at e_0 and takes acc op e_i for each later i. Only `rd` is written, once, with the final value.
- R7: A folding instruction whose op is SUB (code 1) or DIV (code 4) is refused with `illegal`.
- R8: A source longer than 1 but shorter than n makes the instruction illegal.
- R9: A length of 0 on any operand, or a run reaching past register 31, makes the instruction illegal.
- R10: Op codes are 0 ADD, 1 SUB, 2 MUL (low 32 bits), 3 XOR and 4 DIV (unsigned, a zero divisor gives all ones). Codes 5 to 7 are illegal.
- R11: An instruction is accepted only when `busy` is low. Issue requests while busy are ignored. An illegal instruction pulses `illegal` for one cycle, leaves `busy` low and changes no register.
- R12: Elements run in ascending order and read the register file live, so a later element sees results written by earlier elements of the same instruction when the runs overlap.
- R13: Registers may hold different lengths at once, and a new instruction may be issued in the same cycle that `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| issue_valid | input | 1 | Instruction request |
| issue_op | input | 3 | Operation code |
| issue_rd | input | 5 | Destination register |
| issue_rs1 | input | 5 | First source register |
| issue_rs2 | input | 5 | Second source register |
| len_we | input | 1 | Length table write enable |
| len_idx | input | 5 | Register whose length is written |
| len_val | input | 6 | New length value |
| pre_we | input | 1 | Register file preload enable |
| pre_addr | input | 5 | Preload register |
| pre_data | input | 32 | Preload value |
| rd_addr | input | 5 | Read port register |
| rd_data | output | 32 | Read port value |
| busy | output | 1 | Elements being issued |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | One-cycle refusal pulse |

## Verification
The hardest case to reach is a destination run that overlaps its own sources. In that case later elements read values that earlier elements of the same instruction have just written. The bench sets this up on purpose with neighbouring runs, and random register choices over small lengths produce it often. A software model that walks the elements in order predicts the results. Stray issue, length and preload writes are driven during every busy cycle of selected runs, to show that none of them changes the outcome.

// File: rtl/vreg_seq.sv
module vreg_seq #(
  parameter int XLEN = 32,
  parameter int NREG = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       issue_valid,
  input  logic [2:0]                 issue_op,
  input  logic [$clog2(NREG)-1:0]    issue_rd,
  input  logic [$clog2(NREG)-1:0]    issue_rs1,
  input  logic [$clog2(NREG)-1:0]    issue_rs2,
  input  logic                       len_we,
  input  logic [$clog2(NREG)-1:0]    len_idx,
  input  logic [$clog2(NREG):0]      len_val,
  input  logic                       pre_we,
  input  logic [$clog2(NREG)-1:0]    pre_addr,
  input  logic [XLEN-1:0]            pre_data,
  input  logic [$clog2(NREG)-1:0]    rd_addr,
  output logic [XLEN-1:0]            rd_data,
  output logic                       busy,
  output logic                       done,
  output logic                       illegal
);
  localparam int AW = $clog2(NREG);
  localparam int LW = AW + 1;
  localparam logic [2:0] OP_ADD = 3'd0, OP_SUB = 3'd1, OP_MUL = 3'd2,
                         OP_XOR = 3'd3, OP_DIV = 3'd4;

  function automatic logic [XLEN-1:0] alu(input logic [2:0] op,
                                          input logic [XLEN-1:0] a,
                                          input logic [XLEN-1:0] b);
    case (op)
      OP_ADD:  return a + b;
      OP_SUB:  return a - b;
      OP_MUL:  return a * b;
      OP_XOR:  return a ^ b;
      OP_DIV:  return (b == '0) ? '1 : a / b;
      default: return '0;
    endcase
  endfunction

  function automatic logic past_end(input logic [AW-1:0] r, input logic [LW-1:0] l);
    return ({2'b00, r} + {1'b0, l}) > (LW+1)'(NREG);
  endfunction

  logic [XLEN-1:0] rf [NREG];
  logic [LW-1:0]   vl [NREG];

  logic [2:0]      op_q;
  logic [AW-1:0]   rd_q, s1_q, s2_q, idx;
  logic            v1_q, v2_q, red_q;
  logic [LW-1:0]   cnt_q;
  logic [XLEN-1:0] acc;

  logic [LW-1:0] ld, l1, l2, nn;
  logic          red, bad;

  assign ld  = vl[issue_rd];
  assign l1  = vl[issue_rs1];
  assign l2  = vl[issue_rs2];
  assign red = (ld == LW'(1)) && (l1 > LW'(1) || l2 > LW'(1));
  assign nn  = red ? ((l1 > l2) ? l1 : l2) : ld;
  assign bad = (issue_op > OP_DIV)
             || (red && (issue_op == OP_SUB || issue_op == OP_DIV))
             || ld == '0 || l1 == '0 || l2 == '0
             || past_end(issue_rd, ld) || past_end(issue_rs1, l1) || past_end(issue_rs2, l2)
             || (l1 != LW'(1) && l1 < nn) || (l2 != LW'(1) && l2 < nn);

  logic [AW-1:0]   ra, rb, rw;
  logic [XLEN-1:0] elem, fold;
  logic            last;

  assign ra   = s1_q + (v1_q ? idx : '0);
  assign rb   = s2_q + (v2_q ? idx : '0);
  assign rw   = rd_q + (red_q ? '0 : idx);
  assign elem = alu(op_q, rf[ra], rf[rb]);
  assign fold = (idx == '0) ? elem : alu(op_q, acc, elem);
  assign last = ({1'b0, idx} + LW'(1)) == cnt_q;
  assign rd_data = rf[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) begin
        rf[i] <= '0;
        vl[i] <= LW'(1);
      end
      busy <= 1'b0; done <= 1'b0; illegal <= 1'b0;
      op_q <= '0; rd_q <= '0; s1_q <= '0; s2_q <= '0; idx <= '0;
      v1_q <= 1'b0; v2_q <= 1'b0; red_q <= 1'b0; cnt_q <= '0; acc <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (busy) begin
        if (!red_q)    rf[rw] <= elem;
        else if (last) rf[rw] <= fold;
        acc <= fold;
        idx <= idx + AW'(1);
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else begin
        if (issue_valid) begin
          if (bad) illegal <= 1'b1;
          else begin
            busy  <= 1'b1;
            idx   <= '0;
            op_q  <= issue_op;
            rd_q  <= issue_rd;
            s1_q  <= issue_rs1;
            s2_q  <= issue_rs2;
            v1_q  <= l1 != LW'(1);
            v2_q  <= l2 != LW'(1);
            red_q <= red;
            cnt_q <= nn;
          end
        end
        if (len_we) vl[len_idx] <= len_val;
        if (pre_we) rf[pre_addr] <= pre_data;
      end
    end
  end
endmodule

// File: rtl/vreg_seq_chk.sv
module vreg_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic issue_valid,
  input logic busy,
  input logic done,
  input logic illegal
);
  // R4
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(busy));
  // R4
  busy_end_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);
  // R11
  flags_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({busy, done, illegal}));
  // R11
  illegal_from_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(issue_valid && !busy));
  // R11
  start_from_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(issue_valid));
endmodule

bind vreg_seq vreg_seq_chk u_chk (.*);

// File: tb/tb_vreg_seq.sv
module tb_vreg_seq;
  timeunit 1ns;
  timeprecision 10ps;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid = 1'b0;
  logic [2:0] issue_op = '0;
  logic [4:0] issue_rd = '0, issue_rs1 = '0, issue_rs2 = '0;
  logic len_we = 1'b0;
  logic [4:0] len_idx = '0;
  logic [5:0] len_val = '0;
  logic pre_we = 1'b0;
  logic [4:0] pre_addr = '0;
  logic [31:0] pre_data = '0;
  logic [4:0] rd_addr = '0;
  logic [31:0] rd_data;
  logic busy, done, illegal;

  vreg_seq dut (.*);

  always #4 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [31:0] m_rf [32];
  int m_vl [32];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  function automatic logic [31:0] f_op(input int op, input logic [31:0] a, input logic [31:0] b);
    case (op)
      0: return a + b;
      1: return a - b;
      2: return a * b;
      3: return a ^ b;
      4: return (b == 0) ? 32'hffff_ffff : a / b;
      default: return 0;
    endcase
  endfunction

  task automatic model(input int op, input int rd, input int s1, input int s2,
                       output bit ill, output int n);
    int ld = m_vl[rd], l1 = m_vl[s1], l2 = m_vl[s2];
    bit red = (ld == 1) && (l1 > 1 || l2 > 1);
    logic [31:0] acc = 0;
    n = red ? ((l1 > l2) ? l1 : l2) : ld;
    ill = op > 4 || (red && (op == 1 || op == 4)) || ld == 0 || l1 == 0 || l2 == 0
       || rd + ld > 32 || s1 + l1 > 32 || s2 + l2 > 32
       || (l1 != 1 && l1 < n) || (l2 != 1 && l2 < n);
    if (ill) return;
    for (int i = 0; i < n; i++) begin
      logic [31:0] e = f_op(op, m_rf[s1 + ((l1 == 1) ? 0 : i)], m_rf[s2 + ((l2 == 1) ? 0 : i)]);
      if (red) acc = (i == 0) ? e : f_op(op, acc, e);
      else m_rf[rd + i] = e;
    end
    if (red) m_rf[rd] = acc;
  endtask

  task automatic compare(input string tag);
    int bad = 0; logic [31:0] g = 0, x = 0;
    for (int r = 0; r < 32; r++) begin
      rd_addr = 5'(r);
      #0.05;
      if (rd_data !== m_rf[r]) begin
        if (bad == 0) begin g = rd_data; x = m_rf[r]; end
        bad++;
      end
    end
    chk(bad == 0, tag, "register file", g, x);
  endtask

  task automatic set_len(input int r, input int l);
    len_we = 1'b1; len_idx = 5'(r); len_val = 6'(l);
    @(negedge clk);
    len_we = 1'b0;
    m_vl[r] = l;
  endtask

  task automatic preload(input int r, input logic [31:0] v);
    pre_we = 1'b1; pre_addr = 5'(r); pre_data = v;
    @(negedge clk);
    pre_we = 1'b0;
    m_rf[r] = v;
  endtask

  task automatic run(input int op, input int rd, input int s1, input int s2,
                     input bit noise, input string tag);
    bit ill; int n; bit okb = 1;
    issue_valid = 1'b1; issue_op = 3'(op);
    issue_rd = 5'(rd); issue_rs1 = 5'(s1); issue_rs2 = 5'(s2);
    @(negedge clk);
    issue_valid = 1'b0;
    model(op, rd, s1, s2, ill, n);
    if (ill) begin
      chk(illegal === 1'b1 && busy === 1'b0, tag, "illegal pulse {busy,illegal}",
          {30'b0, busy, illegal}, 32'h1);
    end else begin
      for (int k = 0; k < n; k++) begin
        if (!(busy === 1'b1 && done === 1'b0 && illegal === 1'b0)) okb = 0;
        if (noise) begin
          issue_valid = 1'b1; issue_op = 3'($urandom % 5);
          issue_rd = 5'($urandom); issue_rs1 = 5'($urandom); issue_rs2 = 5'($urandom);
          len_we = 1'b1; len_idx = 5'($urandom); len_val = 6'($urandom % 8);
          pre_we = 1'b1; pre_addr = 5'($urandom); pre_data = $urandom;
        end
        @(negedge clk);
        issue_valid = 1'b0; len_we = 1'b0; pre_we = 1'b0;
      end
      chk(okb, tag, "busy held for element count", 32'(okb), 32'h1);
      chk(done === 1'b1 && busy === 1'b0, tag, "done pulse {busy,done}",
          {30'b0, busy, done}, 32'h1);
    end
    compare(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 32; i++) begin m_rf[i] = 0; m_vl[i] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(busy === 1'b0 && done === 1'b0 && illegal === 1'b0, "R1", "flags after reset",
        {29'b0, busy, done, illegal}, 32'h0);
    compare("R1");
    for (int i = 0; i < 32; i++) preload(i, 32'(i * 7 + 3));
    compare("R2");
    run(0, 2, 3, 4, 0, "R1");
    set_len(8, 4); set_len(12, 4); set_len(16, 4);
    run(0, 16, 8, 12, 0, "R4");
    run(2, 16, 5, 12, 0, "R5");
    run(3, 16, 12, 5, 0, "R5");
    run(0, 2, 8, 5, 0, "R6");
    run(3, 3, 8, 12, 0, "R6");
    run(2, 4, 12, 12, 0, "R6");
    run(1, 2, 8, 12, 0, "R7");
    run(4, 2, 8, 5, 0, "R7");
    set_len(20, 2);
    run(0, 16, 20, 8, 0, "R8");
    set_len(30, 4);
    run(0, 30, 30, 30, 0, "R9");
    set_len(9, 0);
    run(0, 1, 9, 2, 0, "R9");
    set_len(9, 1);
    preload(6, 0);
    run(4, 7, 4, 6, 0, "R10");
    preload(6, 32'd5);
    run(4, 7, 28, 6, 0, "R10");
    run(6, 1, 2, 3, 0, "R10");
    run(0, 16, 8, 12, 1, "R11");
    run(2, 16, 12, 5, 1, "R3");
    run(3, 8, 16, 12, 1, "R2");
    set_len(10, 4); set_len(11, 4);
    run(0, 11, 10, 10, 0, "R12");
    set_len(24, 6); set_len(0, 6);
    run(0, 8, 12, 16, 0, "R13");
    run(2, 24, 0, 5, 0, "R13");
    set_len(16, 1);
    run(0, 16, 17, 18, 0, "R3");
    for (int it = 0; it < 400; it++) begin
      if ($urandom % 3 == 0) begin
        int l = ($urandom % 10 == 0) ? 0 : 1 + $urandom % 5;
        set_len($urandom % 32, l);
      end
      if ($urandom % 2 == 0)
        preload($urandom % 32, ($urandom % 2) ? $urandom : 32'($urandom % 8));
      run(($urandom % 8 == 0) ? 5 + $urandom % 3 : $urandom % 5,
          $urandom % 32, $urandom % 32, $urandom % 32, ($urandom % 4) == 0, "R4");
    end
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule